// File: doc/BRIEF.md
# Event-Selectable Performance Counter

This block is one performance-monitor counter that sits beside a processor core. Every clock the core drives a wide bus of event lines. An 8-bit selector register picks which event the counter follows. Two external trigger inputs can also be selected. The counter then adds zero, one or two in each cycle. Two is possible where the core flags a second occurrence in the same cycle on a dedicated dual bit, or where both trigger lines are high together.

Software programs the selector, the enable bit and the count value through three write strobes. It reads all state back on plain output ports. When the 32-bit count rolls past its top value, a sticky overflow flag is raised. The flag stays up until software clears it.

Top module: `evcount`

## Requirements
- R1: After reset the count is 0, the selector is 0x00, the enable bit is 0 and the overflow flag is 0.
- R2: While the enable register is 0 the count keeps its value. A write to the enable register takes effect from the following clock.
- R3: Codes 0x00–0x06, 0x09–0x0C and 0x0F–0x12 add one in each cycle in which event-bus bit 16+code is high. Codes 0x23–0x26 add one in each cycle in which event-bus bit equal to the code value (35–38) is high. This covers level-type stall codes 0x01, 0x02 and 0x11, which add one on every cycle the condition holds.
- R4: Code 0x07 adds one when bus bit 23 is high, or two when bit 9 is high as well. It adds nothing when bit 23 is low.
- R5: Code 0x0D adds one when bus bit 29 is high, or two when bit 15 is high as well. It adds nothing when bit 29 is low.
- R6: Code 0x20 adds one when trigger 0 is high. Code 0x21 adds one when trigger 1 is high. Code 0x22 adds the number of trigger lines that are high (0, 1 or 2).
- R7: Code 0xFF adds one on every enabled clock, whatever the bus and triggers show.
- R8: Any other code (for example 0x08, 0x0E, 0x13–0x1F, 0x27–0xFE) never changes the count.
- R9: The count wraps modulo 2^32. An add of one or two that passes the top value leaves the wrapped result and sets the overflow flag. The flag stays set until clear-overflow is pulsed. A wrap in the same cycle as a clear leaves the flag set.
- R10: A selector write takes effect on the next clock. In the cycle of the write, the increment follows the old code.
- R11: A count write loads the given value on the next clock, replacing that cycle's increment. Clearing is a write of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_sel | input | 1 | Write strobe for the event selector |
| sel_in | input | 8 | New event code |
| wr_ena | input | 1 | Write strobe for the enable bit |
| ena_in | input | 1 | New enable value |
| wr_cnt | input | 1 | Write strobe for the count |
| cnt_in | input | CNT_W | New count value |
| clr_ovf | input | 1 | Clears the overflow flag |
| ev_bus | input | EV_W | Per-cycle event lines and dual bits from the core |
| trig | input | 2 | External trigger lines |
| sel_q | output | 8 | Current event code |
| ena_q | output | 1 | Current enable bit |
| cnt_q | output | CNT_W | Current count |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with its defaults: a 32-bit count and a 40-bit event bus. It never waits for the count to roll over naturally. Instead it loads values just below 2^32 through the count write port. That makes wraps by one and by two reachable within a few cycles, with the real width still in place. Sweeping all 256 selector codes under random bus and trigger patterns shows that every unassigned code is inert and every assigned code reads its own line.

// File: rtl/evcount.sv
module evcount #(
  parameter int CNT_W     = 32,
  parameter int EV_W      = 40,
  parameter int LINE_BASE = 16,
  parameter int DUAL_INSN = 9,
  parameter int DUAL_PC   = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_sel,
  input  logic [7:0]       sel_in,
  input  logic             wr_ena,
  input  logic             ena_in,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic             clr_ovf,
  input  logic [EV_W-1:0]  ev_bus,
  input  logic [1:0]       trig,
  output logic [7:0]       sel_q,
  output logic             ena_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf
);
  localparam int LO_N = 19;
  localparam int HI_N = 4;

  logic [LO_N-1:0] lo;
  logic [HI_N-1:0] hi;
  logic [1:0]      inc, step;
  logic [CNT_W:0]  sum;
  logic            unused_bits;

  assign lo          = ev_bus[LINE_BASE +: LO_N];
  assign hi          = ev_bus[LINE_BASE+LO_N +: HI_N];
  assign unused_bits = ^ev_bus;

  always_comb begin
    inc = 2'd0;
    case (sel_q) inside
      8'h07: inc = lo[7]  ? (ev_bus[DUAL_INSN] ? 2'd2 : 2'd1) : 2'd0;
      8'h0D: inc = lo[13] ? (ev_bus[DUAL_PC]   ? 2'd2 : 2'd1) : 2'd0;
      [8'h00:8'h06], [8'h09:8'h0C], [8'h0F:8'h12]:
             inc = {1'b0, lo[sel_q[4:0]]};
      8'h20: inc = {1'b0, trig[0]};
      8'h21: inc = {1'b0, trig[1]};
      8'h22: inc = {1'b0, trig[0]} + {1'b0, trig[1]};
      [8'h23:8'h26]: inc = {1'b0, hi[sel_q[1:0] - 2'd3]};
      8'hFF: inc = 2'd1;
      default: inc = 2'd0;
    endcase
  end

  assign step = ena_q ? inc : 2'd0;
  assign sum  = {1'b0, cnt_q} + {{(CNT_W-1){1'b0}}, step};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= 8'h00;
      ena_q <= 1'b0;
      cnt_q <= '0;
      ovf   <= 1'b0;
    end else begin
      if (wr_sel) sel_q <= sel_in;
      if (wr_ena) ena_q <= ena_in;
      cnt_q <= wr_cnt ? cnt_in : sum[CNT_W-1:0];
      ovf   <= (!wr_cnt && sum[CNT_W]) || (ovf && !clr_ovf);
    end
  end
endmodule

// File: rtl/evcount_chk.sv
module evcount_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_sel,
  input logic [7:0]       sel_in,
  input logic             wr_cnt,
  input logic [CNT_W-1:0] cnt_in,
  input logic             clr_ovf,
  input logic [7:0]       sel_q,
  input logic             ena_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             ovf
);
  function automatic logic known(input logic [7:0] c);
    return (c <= 8'h12 && c != 8'h08 && c != 8'h0E) ||
           (c >= 8'h20 && c <= 8'h26) || c == 8'hFF;
  endfunction

  a_r2_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ena_q && !wr_cnt) |=> cnt_q == $past(cnt_q));

  a_r7_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_q && sel_q == 8'hFF && !wr_cnt) |=> cnt_q == CNT_W'($past(cnt_q) + 1));

  a_r8_unassigned_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (!known(sel_q) && !wr_cnt) |=> cnt_q == $past(cnt_q));

  a_r9_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cnt |=> CNT_W'(cnt_q - $past(cnt_q)) <= CNT_W'(2));

  a_r9_wrap_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cnt |=> (cnt_q >= $past(cnt_q)) || ovf);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr_ovf) |=> ovf);

  a_r10_sel_next: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel |=> sel_q == $past(sel_in));

  a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt_q == $past(cnt_in));
endmodule

bind evcount evcount_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_evcount.sv
`timescale 1ns/1ps
module tb_evcount;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_sel = 1'b0, wr_ena = 1'b0, wr_cnt = 1'b0, clr_ovf = 1'b0, ena_in = 1'b0;
  logic [7:0]  sel_in = '0;
  logic [31:0] cnt_in = '0;
  logic [39:0] ev_bus = '0;
  logic [1:0]  trig = '0;
  logic [7:0]  sel_q;
  logic        ena_q, ovf;
  logic [31:0] cnt_q;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  logic [7:0]  m_sel;
  logic        m_ena, m_ovf;
  logic [31:0] m_cnt;

  always #2 clk = ~clk;

  evcount dut (.clk, .rst_n, .wr_sel, .sel_in, .wr_ena, .ena_in, .wr_cnt, .cnt_in,
               .clr_ovf, .ev_bus, .trig, .sel_q, .ena_q, .cnt_q, .ovf);

  function automatic int ref_inc(int code, logic [39:0] b, logic [1:0] t);
    if (code == 255) return 1;
    if (code == 32) return int'(t[0]);
    if (code == 33) return int'(t[1]);
    if (code == 34) return int'(t[0]) + int'(t[1]);
    if (code >= 35 && code <= 38) return int'(b[code]);
    if (code == 7)  return b[23] ? (b[9]  ? 2 : 1) : 0;
    if (code == 13) return b[29] ? (b[15] ? 2 : 1) : 0;
    if (code <= 18 && code != 8 && code != 14) return int'(b[16 + code]);
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sel = 0; m_ena = 0; m_cnt = 0; m_ovf = 0;
    end else begin
      longint nxt;
      nxt = longint'(m_cnt) + (m_ena ? ref_inc(int'(m_sel), ev_bus, trig) : 0);
      if (clr_ovf) m_ovf = 0;
      if (wr_cnt) m_cnt = cnt_in;
      else begin
        if (nxt >= 64'h1_0000_0000) m_ovf = 1;
        m_cnt = nxt[31:0];
      end
      if (wr_sel) m_sel = sel_in;
      if (wr_ena) m_ena = ena_in;
    end
  end

  always @(negedge clk) if (rst_n) begin
    checks++;
    if (cnt_q !== m_cnt || ovf !== m_ovf || sel_q !== m_sel || ena_q !== m_ena) begin
      errors++;
      $display("FAIL %s model: cnt %h ovf %b sel %h ena %b, expected %h %b %h %b",
               cur_req, cnt_q, ovf, sel_q, ena_q, m_cnt, m_ovf, m_sel, m_ena);
    end
  end

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: cycles %0d, expected < 100000", cycles);
      report();
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(posedge clk);
    #1;
    wr_sel = 0; wr_ena = 0; wr_cnt = 0; clr_ovf = 0;
  endtask

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  initial begin
    cyc(3); rst_n = 1; cyc();
    chk("R1", cnt_q, 0); chk("R1", {24'd0, sel_q}, 0);
    chk("R1", {31'd0, ena_q}, 0); chk("R1", {31'd0, ovf}, 0);

    cur_req = "R2";
    wr_sel = 1; sel_in = 8'hFF; cyc(5);
    chk("R2", cnt_q, 0);
    wr_ena = 1; ena_in = 1; cyc();
    chk("R2", cnt_q, 0);
    cyc(3);
    chk("R7", cnt_q, 3);

    cur_req = "R11";
    wr_cnt = 1; cnt_in = 1000; cyc();
    chk("R11", cnt_q, 1000);
    cyc();
    chk("R7", cnt_q, 1001);

    cur_req = "R4";
    wr_sel = 1; sel_in = 8'h07; ev_bus = '0; cyc();
    chk("R10", cnt_q, 1002);
    ev_bus[23] = 1; ev_bus[9] = 1; cyc(2);
    chk("R4", cnt_q, 1006);
    ev_bus[9] = 0; cyc();
    chk("R4", cnt_q, 1007);
    ev_bus[23] = 0; ev_bus[9] = 1; cyc();
    chk("R4", cnt_q, 1007);

    cur_req = "R5";
    ev_bus = '0; wr_sel = 1; sel_in = 8'h0D; cyc();
    ev_bus[29] = 1; ev_bus[15] = 1; cyc();
    chk("R5", cnt_q, 1009);
    ev_bus[15] = 0; cyc();
    chk("R5", cnt_q, 1010);

    cur_req = "R6";
    ev_bus = '0; wr_sel = 1; sel_in = 8'h22; cyc();
    trig = 2'b11; cyc(2);
    chk("R6", cnt_q, 1014);
    trig = 2'b10; cyc();
    chk("R6", cnt_q, 1015);
    wr_sel = 1; sel_in = 8'h20; cyc();
    chk("R6", cnt_q, 1016);
    cyc();
    chk("R6", cnt_q, 1016);

    cur_req = "R8";
    trig = 2'b11; ev_bus = '1; wr_sel = 1; sel_in = 8'h13; cyc();
    cyc(3);
    chk("R8", cnt_q, 1017);

    cur_req = "R10";
    wr_sel = 1; sel_in = 8'hFF; cyc();
    chk("R10", cnt_q, 1017);
    cyc();
    chk("R10", cnt_q, 1018);

    cur_req = "R9";
    ev_bus = '0; trig = 0;
    wr_cnt = 1; cnt_in = 32'hFFFF_FFFF; cyc();
    cyc();
    chk("R9", cnt_q, 0); chk("R9", {31'd0, ovf}, 1);
    cyc(3);
    chk("R9", {31'd0, ovf}, 1);
    clr_ovf = 1; cyc();
    chk("R9", {31'd0, ovf}, 0);
    wr_sel = 1; sel_in = 8'h07; wr_cnt = 1; cnt_in = 32'hFFFF_FFFE; cyc();
    ev_bus[23] = 1; ev_bus[9] = 1; clr_ovf = 1; cyc();
    chk("R9", cnt_q, 0); chk("R9", {31'd0, ovf}, 1);

    cur_req = "R3";
    for (int code = 0; code < 256; code++) begin
      wr_sel = 1; sel_in = 8'(code);
      if (code % 5 == 0) begin wr_cnt = 1; cnt_in = 32'hFFFF_FFFB; end
      cyc();
      for (int k = 0; k < 8; k++) begin
        ev_bus = {$urandom, $urandom};
        trig = 2'($urandom);
        if (k == 6) clr_ovf = 1;
        cyc();
      end
    end
    ev_bus = '0; wr_cnt = 1; cnt_in = 77; wr_sel = 1; sel_in = 8'h11; cyc();
    ev_bus[16 + 17] = 1; cyc(4);
    chk("R3", cnt_q, 81);
    ev_bus = '0; ev_bus[36] = 1; wr_sel = 1; sel_in = 8'h24; cyc();
    cyc(2);
    chk("R3", cnt_q, 83);
    report();
  end
endmodule